// File: doc/BRIEF.md
# Masked Skip Pattern Frame Filter

This block decides, frame by frame, whether an incoming Ethernet frame fits a pattern that the host has programmed. It takes the place of ordinary destination-address filtering for management and acknowledgment traffic. Received bytes arrive packed four to a 32-bit dword, with a valid strobe and a marker on the final dword. One cycle after that final dword, the block gives a single-cycle verdict.

The pattern is held in eight 40-bit words, and the host loads them through a plain write port. Each word carries four compare bytes, a per-byte enable mask, a count of incoming dwords to pass over before the compare, and a flag that closes the pattern. The words are used in address order. Gaps longer than seven dwords are built from skip-only words whose mask is empty. Storing the accepted frame, CRC checking and address filters are handled elsewhere.

Top module: `skipmask_frame_filter`

## Requirements
- R1: After reset `res_valid` and `res_match` are 0 and every pattern word is 0, so a frame of 8 or more dwords matches and a frame of 7 or fewer does not.
- R2: A pattern word's bits 31:0 are its compare bytes. Byte n (bits 8n+7:8n) is compared with bits 8n+7:8n of `rx_data`, so bits 7:0 hold the first byte received in that dword.
- R3: Bits 35:32 form a byte mask. When mask bit n is 0, byte n takes no part in the comparison; when it is 1, that byte must be equal.
- R4: Bits 38:36 give a count of 0 to 7. That many accepted dwords are passed over before the word is compared with the next accepted dword.
- R5: Bit 39 marks the final pattern word. Once that word compares equal the frame matches, whatever dwords follow before the end of the frame.
- R6: A word with mask 0 always compares equal, so chained words with skip 7 and mask 0 span gaps longer than 7 dwords.
- R7: Words are used in address order, starting from word 0 for every frame.
- R8: A masked byte that differs makes the frame a no-match, even if later dwords would fit.
- R9: If the frame ends before the final pattern word has been compared, the result is no-match.
- R10: If no word has bit 39 set, word 7 acts as the final word.
- R11: When a dword with `rx_last` is accepted on a clock edge, `res_valid` is 1 for exactly the following cycle and `res_match` carries the verdict. At all other times both outputs are 0, and the next frame starts from a clean state.
- R12: When a pattern write and a compare touch the same word in one cycle, the compare uses the old contents. The new contents apply from the next cycle on.
- R13: `rx_data` and `rx_last` are ignored while `rx_valid` is 0, so idle cycles inside a frame do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pw_we | input | 1 | Pattern word write strobe |
| pw_addr | input | 3 | Pattern word index |
| pw_data | input | 40 | Pattern word: {final, skip[2:0], mask[3:0], bytes[31:0]} |
| rx_valid | input | 1 | Received dword is valid |
| rx_data | input | 32 | Received dword; bits 7:0 hold the earliest byte |
| rx_last | input | 1 | Marks the final dword of the frame |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_match | output | 1 | Verdict: 1 means the frame fits the pattern |

## Verification
Two functions can land on the same clock edge: a host write to a pattern word, and the compare of a received dword against that same word. The bench provokes this by raising `pw_we` and `rx_valid` in the same cycle, aimed at the word the matcher is currently using. It judges the outcome by the verdict. The frame must match against the old contents, and a following frame must be judged against the new ones. Random patterns and frames with random idle gaps are checked against a bench model that walks the pattern in a plain loop.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    localparam int SFM_WORDS   = 8;
    localparam int SFM_BYTES   = 4;
    localparam int SFM_SKIP_W  = 3;
    localparam int SFM_IDX_W   = $clog2(SFM_WORDS);
    localparam int SFM_DW_W    = 8 * SFM_BYTES;
    localparam int SFM_WORD_W  = 1 + SFM_SKIP_W + SFM_BYTES + SFM_DW_W;

    typedef struct packed {
        logic                  fin;
        logic [SFM_SKIP_W-1:0] skip;
        logic [SFM_BYTES-1:0]  mask;
        logic [SFM_DW_W-1:0]   data;
    } sfm_word_t;

    typedef struct packed {
        logic [SFM_IDX_W-1:0]  idx;
        logic [SFM_SKIP_W-1:0] scnt;
        logic                  done;
        logic                  fail;
    } sfm_walk_t;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_SKIP,
        ACT_CMP
    } sfm_act_e;

    function automatic logic sfm_is_final(logic fin, logic [SFM_IDX_W-1:0] idx);
        return fin || (idx == SFM_IDX_W'(SFM_WORDS - 1));
    endfunction

endpackage

// File: rtl/sfm_pattern_store.sv
module sfm_pattern_store
    import sfm_pkg::*;
#(
    parameter int NWORDS = SFM_WORDS,
    localparam int AW = $clog2(NWORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  sfm_word_t       wdata,
    input  logic [AW-1:0]   raddr,
    output sfm_word_t       rword
);

    sfm_word_t mem [NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered storage: a read in the write cycle sees the old word
    assign rword = mem[raddr];

    p_write_lands_r12: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && !$past(rst)) |-> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/sfm_dword_cmp.sv
module sfm_dword_cmp
    import sfm_pkg::*;
(
    input  logic [SFM_DW_W-1:0]  rx_dw,
    input  logic [SFM_DW_W-1:0]  pat,
    input  logic [SFM_BYTES-1:0] mask,
    output logic                 equal
);

    logic [SFM_BYTES-1:0] lane_ok;

    for (genvar b = 0; b < SFM_BYTES; b++) begin : g_lane
        assign lane_ok[b] = !mask[b] || (rx_dw[8*b +: 8] == pat[8*b +: 8]);
    end

    assign equal = &lane_ok;

    always_comb begin
        if (mask == '0) begin
            p_empty_mask_equal_r6: assert (equal);
        end
    end

endmodule

// File: rtl/sfm_walker.sv
module sfm_walker
    import sfm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_valid,
    input  logic                  rx_last,
    input  logic [SFM_SKIP_W-1:0] cur_skip,
    input  logic                  cur_fin,
    input  logic                  hit,
    output logic [SFM_IDX_W-1:0]  idx,
    output logic                  res_valid,
    output logic                  res_match
);

    sfm_walk_t st, nxt;
    sfm_act_e  act;
    logic      eof;
    logic      verdict;

    assign eof = rx_valid && rx_last;
    assign idx = st.idx;

    always_comb begin
        act = ACT_IDLE;
        if (rx_valid && !st.done && !st.fail) begin
            act = (st.scnt < cur_skip) ? ACT_SKIP : ACT_CMP;
        end
    end

    always_comb begin
        nxt = st;
        case (act)
            ACT_SKIP: nxt.scnt = st.scnt + 1'b1;
            ACT_CMP: begin
                if (!hit) begin
                    nxt.fail = 1'b1;
                end else if (sfm_is_final(cur_fin, st.idx)) begin
                    nxt.done = 1'b1;
                end else begin
                    nxt.idx  = st.idx + 1'b1;
                    nxt.scnt = '0;
                end
            end
            default: ;
        endcase
    end

    assign verdict = nxt.done && !nxt.fail;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '0;
            res_valid <= 1'b0;
            res_match <= 1'b0;
        end else begin
            res_valid <= eof;
            res_match <= eof && verdict;
            st        <= eof ? '0 : nxt;
        end
    end

    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (st.fail && !eof) |=> st.fail);

    p_idx_forward_r7: assert property (@(posedge clk) disable iff (rst)
        !eof |=> (st.idx >= $past(st.idx)));

    p_done_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (st.done && !eof) |=> (st.done && $stable(st.idx)));

    p_fresh_frame_r11: assert property (@(posedge clk) disable iff (rst)
        eof |=> (st.idx == '0 && !st.done && !st.fail));

endmodule

// File: rtl/skipmask_frame_filter.sv
module skipmask_frame_filter
    import sfm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pw_we,
    input  logic [SFM_IDX_W-1:0]  pw_addr,
    input  logic [SFM_WORD_W-1:0] pw_data,
    input  logic                  rx_valid,
    input  logic [SFM_DW_W-1:0]   rx_data,
    input  logic                  rx_last,
    output logic                  res_valid,
    output logic                  res_match
);

    sfm_word_t            wr_word;
    sfm_word_t            cur;
    logic [SFM_IDX_W-1:0] idx;
    logic                 hit;

    assign wr_word = sfm_word_t'(pw_data);

    sfm_pattern_store #(.NWORDS(SFM_WORDS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (pw_we),
        .waddr (pw_addr),
        .wdata (wr_word),
        .raddr (idx),
        .rword (cur)
    );

    sfm_dword_cmp u_cmp (
        .rx_dw (rx_data),
        .pat   (cur.data),
        .mask  (cur.mask),
        .equal (hit)
    );

    sfm_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_last   (rx_last),
        .cur_skip  (cur.skip),
        .cur_fin   (cur.fin),
        .hit       (hit),
        .idx       (idx),
        .res_valid (res_valid),
        .res_match (res_match)
    );

    p_quiet_match_r11: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_match);

    p_result_after_eof_r11: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(rx_valid && rx_last));

endmodule

// File: tb/skipmask_frame_filter_bench.sv
module skipmask_frame_filter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pw_we = 1'b0;
    logic [2:0]  pw_addr = '0;
    logic [39:0] pw_data = '0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        rx_last = 1'b0;
    logic        res_valid, res_match;

    int total = 0;
    int bad = 0;
    logic [39:0] pat [8];
    logic [31:0] frm [64];
    logic got_v, got_m;

    always #10 clk = ~clk;

    skipmask_frame_filter u_skipmask_frame_filter (
        .clk(clk), .rst(rst), .pw_we(pw_we), .pw_addr(pw_addr), .pw_data(pw_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .res_valid(res_valid), .res_match(res_match)
    );

    function automatic logic [39:0] mk(bit fin, int skip, logic [3:0] mask, logic [31:0] d);
        return {fin, 3'(skip), mask, d};
    endfunction

    function automatic bit ref_match(int n);
        int pos = 0;
        for (int w = 0; w < 8; w++) begin
            pos += int'(pat[w][38:36]);
            if (pos >= n) return 1'b0;
            for (int b = 0; b < 4; b++)
                if (pat[w][32+b] && frm[pos][8*b +: 8] != pat[w][8*b +: 8]) return 1'b0;
            pos++;
            if (pat[w][39]) return 1'b1;
        end
        return 1'b1;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [39:0] d);
        @(negedge clk);
        pw_we = 1'b1; pw_addr = 3'(a); pw_data = d;
        @(negedge clk);
        pw_we = 1'b0;
        pat[a] = d;
    endtask

    task automatic clear_pat();
        for (int w = 0; w < 8; w++) wr(w, '0);
    endtask

    task automatic send(int n, int gapmax);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = frm[i]; rx_last = (i == n - 1);
            if (i != n - 1 && gapmax > 0) begin
                int g = int'($urandom % 32'(gapmax + 1));
                for (int k = 0; k < g; k++) begin
                    @(negedge clk);
                    rx_valid = 1'b0; rx_last = ($urandom % 2) == 1; rx_data = $urandom;
                end
            end
        end
        @(negedge clk);
        got_v = res_valid; got_m = res_match;
        rx_valid = 1'b0; rx_last = 1'b0;
        @(negedge clk);
        chk("R11 pulse ends", int'(res_valid), 0);
    endtask

    task automatic run(string tag, int n, int gapmax, bit exp);
        send(n, gapmax);
        chk({tag, " valid"}, int'(got_v), 1);
        chk({tag, " match"}, int'(got_m), int'(exp));
    endtask

    task automatic fill_rand(int n);
        for (int i = 0; i < n; i++) frm[i] = $urandom;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        for (int w = 0; w < 8; w++) pat[w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset valid", int'(res_valid), 0);
        chk("R1 reset match", int'(res_match), 0);

        // R1 / R10: zero pattern, word 7 closes it
        fill_rand(8);  run("R1 eight dwords", 8, 0, 1'b1);
        fill_rand(7);  run("R10 seven dwords", 7, 0, 1'b0);

        // R2: byte lane order
        wr(0, mk(1, 0, 4'b0001, 32'h0000_00AA));
        frm[0] = 32'h1234_56AA; run("R2 low byte first", 1, 0, 1'b1);
        frm[0] = 32'hAA00_0000; run("R2 wrong lane", 1, 0, 1'b0);

        // R3: partial mask
        wr(0, mk(1, 0, 4'b0101, 32'h1122_3344));
        frm[0] = 32'hFF22_FF44; run("R3 masked bytes ignored", 1, 0, 1'b1);
        frm[0] = 32'hFF22_FF45; run("R3 enabled byte differs", 1, 0, 1'b0);

        // R4: skip count
        wr(0, mk(1, 3, 4'hF, 32'hCAFE_0001));
        fill_rand(4); frm[3] = 32'hCAFE_0001; run("R4 skip three", 4, 0, 1'b1);
        fill_rand(4); frm[2] = 32'hCAFE_0001; frm[3] = 32'h0; run("R4 off by one", 4, 0, 1'b0);

        // R5: trailing data after the final word
        wr(0, mk(1, 0, 4'hF, 32'h5555_0000));
        fill_rand(20); frm[0] = 32'h5555_0000; run("R5 tail ignored", 20, 0, 1'b1);

        // R6 / R9: long gap from skip-only words
        wr(0, mk(0, 7, 4'h0, 32'hDEAD_BEEF));
        wr(1, mk(0, 7, 4'h0, 32'h0BAD_F00D));
        wr(2, mk(1, 0, 4'hF, 32'h7777_1234));
        fill_rand(17); frm[16] = 32'h7777_1234; run("R6 gap of sixteen", 17, 0, 1'b1);
        fill_rand(16); run("R9 frame too short", 16, 0, 1'b0);

        // R7 / R8: order and sticky mismatch
        clear_pat();
        wr(0, mk(0, 0, 4'hF, 32'hA0A0_A0A0));
        wr(1, mk(1, 0, 4'hF, 32'hB1B1_B1B1));
        frm[0] = 32'hA0A0_A0A0; frm[1] = 32'hB1B1_B1B1; run("R7 in order", 2, 0, 1'b1);
        frm[0] = 32'hB1B1_B1B1; frm[1] = 32'hA0A0_A0A0; run("R7 swapped", 2, 0, 1'b0);
        frm[0] = 32'h0; frm[1] = 32'hA0A0_A0A0; frm[2] = 32'hB1B1_B1B1;
        run("R8 early mismatch", 3, 0, 1'b0);
        frm[0] = 32'hA0A0_A0A0; frm[1] = 32'hB1B1_B1B1; run("R11 clean restart", 2, 0, 1'b1);

        // R13: idle cycles with junk inside a frame
        for (int t = 0; t < 4; t++) begin
            frm[0] = 32'hA0A0_A0A0; frm[1] = 32'hB1B1_B1B1; run("R13 idle junk", 2, 4, 1'b1);
        end

        // R12: write and compare of word 0 in the same cycle
        wr(0, mk(1, 0, 4'hF, 32'h1111_1111));
        @(negedge clk);
        pw_we = 1'b1; pw_addr = 3'd0; pw_data = mk(1, 0, 4'hF, 32'h2222_2222);
        rx_valid = 1'b1; rx_data = 32'h1111_1111; rx_last = 1'b1;
        @(negedge clk);
        pw_we = 1'b0; rx_valid = 1'b0; rx_last = 1'b0;
        pat[0] = mk(1, 0, 4'hF, 32'h2222_2222);
        chk("R12 same cycle valid", int'(res_valid), 1);
        chk("R12 old word used", int'(res_match), 1);
        frm[0] = 32'h1111_1111; run("R12 old data rejected", 1, 0, 1'b0);
        frm[0] = 32'h2222_2222; run("R12 new data applies", 1, 0, 1'b1);

        // Random patterns and frames (R4, R7, R8 mix)
        for (int p = 0; p < 20; p++) begin
            for (int w = 0; w < 8; w++) begin
                int sk = ($urandom % 6 == 0) ? 7 : int'($urandom % 3);
                wr(w, mk(($urandom % 4) == 0, sk, 4'($urandom), $urandom));
            end
            for (int f = 0; f < 15; f++) begin
                int n = 1 + int'($urandom % 40);
                int pos = 0;
                fill_rand(64);
                if ($urandom % 4 != 0) begin
                    for (int w = 0; w < 8; w++) begin
                        pos += int'(pat[w][38:36]);
                        if (pos >= 64) break;
                        for (int b = 0; b < 4; b++)
                            if (pat[w][32+b]) frm[pos][8*b +: 8] = pat[w][8*b +: 8];
                        pos++;
                        if (pat[w][39]) break;
                    end
                    if ($urandom % 4 == 0) frm[$urandom % 32'(n)] ^= 32'(1) << ($urandom % 32);
                end
                run("R4 R7 R8 random", n, int'($urandom % 3), ref_match(n));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule